// File: doc/BRIEF.md
# Binary-Search Best-Match Locator

This controller finds which of several stored rows is closest to a query. Each row produces an analog level, and a lower level means a closer match. A digital-to-analog converter turns a shared reference code into a voltage. Every row has a comparator that reports, active-low, when its level lies below that reference. The controller steps the reference code through a binary search, starting at the top bit. At each step it moves toward the lowest row level, so the decisions taken together spell out that level as a result code.

After a start request, the controller holds the reference at mid-scale while the matchlines settle. It then makes one decision per cycle, one per code bit. On each cycle where at least one comparator flag was low, it keeps a copy of the flag vector. After the last decision, a priority encoder turns the last kept vector into a single row index. Ties go to the lowest-numbered row. A valid flag says whether any row was ever below the reference.

Top module: `bestmatch_sar_ctrl`

## Requirements
- R1: After reset the outputs are as follows: `done` = 0, `winner_vld` = 0, `winner_idx` = 0, `result_code` = 0, and `ref_code` is at mid-scale (only the top bit set, 64 for a 7-bit code).
- R2: When `start` is accepted in idle, `ref_code` goes to mid-scale. It holds there for the SETTLE_CYC cycles that follow the accepting edge and for the cycle after them, before any decision.
- R3: A flag in `cmp_n` is 0 when that row's level is below `ref_code`. If all flags are 1, the bit under trial stays 1; otherwise it is cleared. The next lower bit is then set for the next trial. As a result, `result_code` equals the smallest row level, taken over levels 0 to 2^CODE_W-1.
- R4: `done` is high for exactly one cycle. It rises SETTLE_CYC+CODE_W+1 rising edges after the edge that accepted `start`.
- R5: When `done` is high and a win is valid, `winner_idx` names a row whose level equals the minimum. Among equal minima, it names the lowest-numbered row.
- R6: If no decision cycle saw a low flag (every level at 2^CODE_W-1), then when `done` is high: `winner_vld` = 0, `winner_idx` = 0 and `result_code` is all ones. Otherwise `winner_vld` = 1.
- R7: A `start` that arrives while a search runs is ignored. The running search keeps its timing and its results, and `done` pulses only once.
- R8: `result_code`, `winner_idx` and `winner_vld` keep their values while idle, until the next search completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; comparator snapshot taken on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search (accepted only when idle) |
| cmp_n | input | ROWS | Per-row comparator flags, 0 = row level below reference |
| ref_code | output | CODE_W | Reference code to the DAC |
| result_code | output | CODE_W | Resolved lowest level |
| winner_idx | output | IDX_W | Index of the best-matching row |
| winner_vld | output | 1 | Winner index is meaningful |
| done | output | 1 | One-cycle completion pulse |

## Verification
The search state is visible on `ref_code` every cycle. A wrong trial bit or a wrong decision therefore shows up as a wrong reference on the next cycle, and it carries into `result_code` one cycle before `done`. A wrong snapshot in the winner bank stays hidden until the encoder reads it. It then shows at `done` as the wrong row, a wrong tie choice, or a `winner_vld` that disagrees with `result_code` being all ones. Sequencing faults show up as a `done` that arrives at the wrong latency or lasts more than one cycle.

// File: rtl/bmsar_pkg.sv
package bmsar_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_TRIAL  = 2'd2,
      ST_REPORT = 2'd3
   } sar_state_e;
endpackage

// File: rtl/bmsar_step.sv
// Next reference code after one trial decision.
module bmsar_step #(
   parameter int CODE_W = 7
) (
   input  logic [CODE_W-1:0] cur_code,
   input  logic [CODE_W-1:0] trial_oh,
   input  logic              go_up,
   output logic [CODE_W-1:0] nxt_code
);
   logic [CODE_W-1:0] kept;

   always_comb begin
      kept     = go_up ? cur_code : (cur_code & ~trial_oh);
      nxt_code = kept | (trial_oh >> 1);
   end
endmodule

// File: rtl/bmsar_hitbank.sv
// Comparator snapshot plus bank of the last flag vector with any low flag.
module bmsar_hitbank #(
   parameter int ROWS      = 8,
   parameter bit SNAP_FALL = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            sample,
   input  logic [ROWS-1:0] cmp_n,
   output logic            all_high,
   output logic [ROWS-1:0] hits
);
   logic [ROWS-1:0] snap_n;

   generate
      if (SNAP_FALL) begin : g_fall_snap
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) snap_n <= '1;
            else        snap_n <= cmp_n;
         end
      end else begin : g_direct
         assign snap_n = cmp_n;
      end
   endgenerate

   assign all_high = &snap_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  hits <= '0;
      else if (clear)              hits <= '0;
      else if (sample && !all_high) hits <= ~snap_n;
   end
endmodule

// File: rtl/bmsar_prienc.sv
// Lowest set bit wins.
module bmsar_prienc #(
   parameter int ROWS  = 8,
   parameter int IDX_W = 3
) (
   input  logic [ROWS-1:0]  vec,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   always_comb begin
      idx = '0;
      for (int i = ROWS - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
      any = |vec;
   end
endmodule

// File: rtl/bestmatch_sar_ctrl.sv
module bestmatch_sar_ctrl
   import bmsar_pkg::*;
#(
   parameter int ROWS       = 8,
   parameter int CODE_W     = 7,
   parameter int SETTLE_CYC = 2,
   parameter bit SNAP_FALL  = 1'b1,
   parameter int IDX_W      = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ROWS-1:0]   cmp_n,
   output logic [CODE_W-1:0] ref_code,
   output logic [CODE_W-1:0] result_code,
   output logic [IDX_W-1:0]  winner_idx,
   output logic              winner_vld,
   output logic              done
);
   localparam int CNT_W = $clog2(SETTLE_CYC + 1);
   localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);
   localparam logic [CNT_W-1:0]  SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

   generate
      if (ROWS < 2) begin : g_bad_rows
         $error("ROWS must be at least 2");
      end
      if (CODE_W < 2) begin : g_bad_code
         $error("CODE_W must be at least 2");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 1");
      end
      if ((1 << IDX_W) < ROWS) begin : g_bad_idx
         $error("IDX_W too narrow for ROWS");
      end
   endgenerate

   sar_state_e        state;
   logic [CNT_W-1:0]  settle_cnt;
   logic [CODE_W-1:0] trial_oh;
   logic [CODE_W-1:0] code_nxt;
   logic              all_high;
   logic [ROWS-1:0]   hits;
   logic [IDX_W-1:0]  enc_idx;
   logic              enc_any;
   logic              bank_clear;
   logic              bank_sample;

   assign bank_clear  = (state == ST_IDLE) && start;
   assign bank_sample = (state == ST_TRIAL);

   bmsar_hitbank #(.ROWS(ROWS), .SNAP_FALL(SNAP_FALL)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (bank_clear),
      .sample   (bank_sample),
      .cmp_n    (cmp_n),
      .all_high (all_high),
      .hits     (hits)
   );

   bmsar_step #(.CODE_W(CODE_W)) u_step (
      .cur_code (ref_code),
      .trial_oh (trial_oh),
      .go_up    (all_high),
      .nxt_code (code_nxt)
   );

   bmsar_prienc #(.ROWS(ROWS), .IDX_W(IDX_W)) u_enc (
      .vec (hits),
      .idx (enc_idx),
      .any (enc_any)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         settle_cnt  <= '0;
         trial_oh    <= '0;
         ref_code    <= MID;
         result_code <= '0;
         winner_idx  <= '0;
         winner_vld  <= 1'b0;
         done        <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state      <= ST_SETTLE;
                  settle_cnt <= '0;
                  ref_code   <= MID;
                  trial_oh   <= MID;
               end
            end
            ST_SETTLE: begin
               if (settle_cnt == SETTLE_LAST) state <= ST_TRIAL;
               else settle_cnt <= settle_cnt + 1'b1;
            end
            ST_TRIAL: begin
               ref_code <= code_nxt;
               trial_oh <= trial_oh >> 1;
               if (trial_oh[0]) begin
                  result_code <= code_nxt;
                  state       <= ST_REPORT;
               end
            end
            ST_REPORT: begin
               winner_idx <= enc_idx;
               winner_vld <= enc_any;
               done       <= 1'b1;
               state      <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bestmatch_sar_ctrl_chk.sv
module bestmatch_sar_ctrl_chk
   import bmsar_pkg::*;
#(
   parameter int ROWS   = 8,
   parameter int CODE_W = 7,
   parameter int IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input sar_state_e        state,
   input logic [CODE_W-1:0] ref_code,
   input logic [CODE_W-1:0] result_code,
   input logic [IDX_W-1:0]  winner_idx,
   input logic              winner_vld,
   input logic              done
);
   localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

   // R2
   start_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start) |=> (ref_code == MID));

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   winner_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      winner_vld |-> (int'(winner_idx) < ROWS));

   // R6
   valid_vs_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (winner_vld == (result_code != '1)));

   // R8
   winner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(winner_idx) |-> done);
endmodule

bind bestmatch_sar_ctrl bestmatch_sar_ctrl_chk #(
   .ROWS(ROWS), .CODE_W(CODE_W), .IDX_W(IDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .state       (state),
   .ref_code    (ref_code),
   .result_code (result_code),
   .winner_idx  (winner_idx),
   .winner_vld  (winner_vld),
   .done        (done)
);

// File: tb/bestmatch_sar_ctrl_test.sv
module bestmatch_sar_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int ROWS   = 8;
   localparam int CODE_W = 7;
   localparam int SETTLE = 2;
   localparam int IDX_W  = 3;
   localparam int TOP    = (1 << CODE_W) - 1;
   localparam int LAT    = SETTLE + CODE_W + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [ROWS-1:0]   cmp_n;
   logic [CODE_W-1:0] ref_code, result_code;
   logic [IDX_W-1:0]  winner_idx;
   logic              winner_vld, done;

   int lvl [ROWS];
   int checks = 0;
   int fails  = 0;
   int seed   = 12345;

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural comparators: 0 when the row level is below the reference
   always_comb begin
      for (int i = 0; i < ROWS; i++) cmp_n[i] = !(lvl[i] < int'(ref_code));
   end

   bestmatch_sar_ctrl #(.ROWS(ROWS), .CODE_W(CODE_W), .SETTLE_CYC(SETTLE)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmp_n(cmp_n),
      .ref_code(ref_code), .result_code(result_code),
      .winner_idx(winner_idx), .winner_vld(winner_vld), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   // one search; poke_at >= 0 raises start again in that cycle of the run
   task automatic run_search(input int poke_at);
      int n = 0;
      int mn = TOP;
      int widx = 0;
      bit found = 0;
      logic [CODE_W-1:0] r_res;
      logic [IDX_W-1:0]  r_idx;
      logic              r_vld;
      for (int i = 0; i < ROWS; i++) if (lvl[i] < mn) mn = lvl[i];
      for (int i = 0; i < ROWS; i++) if (!found && lvl[i] == mn) begin widx = i; found = 1; end
      @(negedge clk); start = 1'b1;
      @(posedge clk);
      @(negedge clk); start = 1'b0;
      while (!done && n < 40) begin
         // R2: mid-scale during settle
         if (n <= SETTLE) chk(ref_code == (1 << (CODE_W-1)), "R2 settle ref", ref_code, 1 << (CODE_W-1));
         if (n == poke_at) start = 1'b1;
         @(posedge clk);
         @(negedge clk); start = 1'b0;
         n++;
      end
      chk(n == LAT, "R4 latency", n, LAT);
      chk(int'(result_code) == mn, "R3 result code", result_code, mn);
      chk(winner_vld == (mn < TOP), "R6 winner valid", winner_vld, mn < TOP);
      if (mn < TOP) chk(int'(winner_idx) == widx, "R5 winner index", winner_idx, widx);
      else          chk(winner_idx == 0, "R6 winner index none", winner_idx, 0);
      r_res = result_code; r_idx = winner_idx; r_vld = winner_vld;
      @(posedge clk); @(negedge clk);
      chk(!done, "R4 one-cycle done", done, 0);
      if (poke_at >= 0) begin
         // R7: no second completion from the ignored start
         for (int k = 0; k < LAT + 2; k++) begin
            @(posedge clk); @(negedge clk);
            chk(!done, "R7 ignored start", done, 0);
         end
      end
      @(posedge clk); @(negedge clk);
      chk(result_code == r_res && winner_idx == r_idx && winner_vld == r_vld,
          "R8 hold", {result_code, winner_idx, winner_vld}, {r_res, r_idx, r_vld});
   endtask

   function automatic int lcg();
      seed = seed * 1103515245 + 12345;
      return (seed >>> 8) & 32'h7fffffff;
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      for (int i = 0; i < ROWS; i++) lvl[i] = TOP;
      repeat (3) @(negedge clk);
      // R1 reset values
      chk(done == 0, "R1 done", done, 0);
      chk(winner_vld == 0, "R1 valid", winner_vld, 0);
      chk(winner_idx == 0, "R1 index", winner_idx, 0);
      chk(result_code == 0, "R1 result", result_code, 0);
      chk(ref_code == 64, "R1 ref mid", ref_code, 64);
      rst_n = 1'b1;
      @(negedge clk);

      // all rows tied at each level: lowest index wins (R5), top level gives none (R6)
      for (int v = 0; v <= TOP; v++) begin
         for (int i = 0; i < ROWS; i++) lvl[i] = v;
         run_search(-1);
      end
      // single low row at boundary levels
      for (int r = 0; r < ROWS; r++) begin
         foreach (lvl[i]) lvl[i] = TOP;
         lvl[r] = 0;   run_search(-1);
         lvl[r] = 63;  run_search(-1);
         lvl[r] = 64;  run_search(-1);
         lvl[r] = 126; run_search(-1);
      end
      // pseudo-random levels with forced ties
      for (int t = 0; t < 200; t++) begin
         for (int i = 0; i < ROWS; i++) lvl[i] = lcg() % (TOP + 1);
         if (t % 3 == 0) lvl[lcg() % ROWS] = lvl[lcg() % ROWS];
         run_search(-1);
      end
      // R7 start while busy
      for (int p = 0; p < 6; p++) begin
         for (int i = 0; i < ROWS; i++) lvl[i] = 20 + ((i * 37 + p) % 90);
         run_search(p * 2);
      end
      finish_run();
   end
endmodule